// File: doc/BRIEF.md
# Serial Configuration and Fault Readback Registers for a Six-Channel Low-Side Pre-Driver

This block is the serial register file of a six-channel low-side gate pre-driver. A host reaches it over a mode-0 SPI slave port. The port clocks are oversampled by the block's own clock. Each chip-select frame carries one command: a 3-bit address followed by six data bits. The block acts on the command only after chip select returns high. The block holds four registers: gate select, disable mode, threshold/refresh configuration and flag mask. Their contents drive the channel state machines and the threshold generator that sit next to it.

The per-channel fault machines report 2-bit fault codes into a 12-bit fault latch. Every frame, whatever its address, shifts the whole latch out on MISO. The latch is then emptied when the frame is accepted. Two active-low flags summarise the unmasked channels. The fault flag is re-evaluated at each accepted frame end. The status flag follows the live per-channel status inputs. A soft-reset enable input clears the gate-select register, the fault latch and both flags, and it blocks new gate-select writes. While it is low, the other registers can still be written.

Top module: `lsd_serial_regs`

## Requirements
- R1: After reset, gate select, disable mode, configuration and mask registers are all zero, both flags are high (inactive) and MISO is low. A zero mode bit selects auto-retry for that channel.
- R2: An accepted frame has exactly 12 SCLK rising edges, with MOSI sampled on each rising edge. The last nine bits received, MSB first, form address A2..A0 then data D5..D0. The command is decoded when chip select rises. Address 000 writes disable mode (bit set = latch-off), 001 writes gate select, 010 writes configuration and 011 writes the flag mask.
- R3: Configuration bits [1:0] and [4:3] appear on thr_lo_o and thr_hi_o as the threshold codes for channels 0-2 and 3-5 (00/01/10/11 = 25/50/75/100 %). Bits 2 and 5 appear on rfr_lo_o and rfr_hi_o (0 = short, 1 = long refresh).
- R4: A command whose A2 bit is 1 changes no register.
- R5: A frame with any count of SCLK rising edges other than 12 writes no register and leaves the fault latch untouched.
- R6: A fault report with a nonzero code (01 open load, 10 short to ground, 11 shorted load) is held in the latch. Each frame shifts out all 12 latch bits, MSB first, starting with channel 5 bit 1, with the first bit valid before the first SCLK edge. An accepted frame clears the latch, except for a report that arrives in the same cycle.
- R7: fault_flag_n_o is updated only at an accepted frame end. It goes low if any channel that is unmasked (mask bit 1) has a nonzero latched code, and high otherwise.
- R8: When a mask bit goes from 0 to 1, the status flag follows after that one frame and the fault flag only after the next frame. When a mask bit goes from 1 to 0, both flags follow after that one frame. stat_flag_n_o is low while any unmasked channel's status input is high.
- R9: While en_i is low, gate select and the fault latch are cleared, both flags are high, gate-select writes and fault reports are ignored, and the other registers can still be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out, low when not selected |
| en_i | input | 1 | Soft-reset enable, low clears |
| rpt_vld_i | input | 6 | Per-channel fault report strobe |
| rpt_code_i | input | 12 | Per-channel 2-bit fault code, channel c at [2c+1:2c] |
| stat_i | input | 6 | Per-channel live status |
| gate_sel_o | output | 6 | Gate-select register |
| latch_off_o | output | 6 | Disable mode, 1 = latch-off |
| thr_lo_o | output | 2 | Threshold code, channels 0-2 |
| rfr_lo_o | output | 1 | Long refresh select, channels 0-2 |
| thr_hi_o | output | 2 | Threshold code, channels 3-5 |
| rfr_hi_o | output | 1 | Long refresh select, channels 3-5 |
| fault_flag_n_o | output | 1 | Active-low masked fault flag |
| stat_flag_n_o | output | 1 | Active-low masked status flag |

## Verification
A frame's end can coincide with a new fault report. In that cycle, emptying the latch and capturing the report compete for the same bits. The bench holds a report strobe across a whole frame, including its chip-select rise. It then requires the code to appear both in that frame's readback and in the readback of the next frame. A mask write can also coincide with the fault-flag update at the same frame end. The bench checks the flag after the writing frame and again after the following null frame, in both mask directions, against the one-frame and two-frame latencies.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int ADDR_W = 3;
  localparam int RCFG_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MODE = 3'b000,
    ADR_GATE = 3'b001,
    ADR_RCFG = 3'b010,
    ADR_MASK = 3'b011
  } reg_addr_e;
endpackage

// File: rtl/lsd_spi_front.sv
module lsd_spi_front
  import lsd_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk_i,
  input  logic                    csn_i,
  input  logic                    mosi_i,
  input  logic [2*NCH-1:0]        snap_i,
  output logic                    miso_o,
  output logic                    commit_o,
  output logic [ADDR_W+NCH-1:0]   cmd_o
);
  localparam int FRAME_LEN = 2 * NCH;
  localparam int CMD_W     = ADDR_W + NCH;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_LEN);

  logic [1:0] sclk_s, csn_s, mosi_s;
  logic       sclk_d, csn_d;
  logic [CMD_W-1:0]     in_q, in_d;
  logic [2*NCH-1:0]     out_q, out_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic cs_act, sclk_rise, sclk_fall, cs_fall, cs_rise;

  always_comb begin
    cs_act    = ~csn_s[1];
    sclk_rise = cs_act & sclk_s[1] & ~sclk_d;
    sclk_fall = cs_act & ~sclk_s[1] & sclk_d;
    cs_fall   = ~csn_s[1] & csn_d;
    cs_rise   = csn_s[1] & ~csn_d;

    in_d  = in_q;
    out_d = out_q;
    cnt_d = cnt_q;
    if (cs_fall) begin
      out_d = snap_i;
      cnt_d = '0;
    end else begin
      if (sclk_rise) begin
        in_d = {in_q[CMD_W-2:0], mosi_s[1]};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (sclk_fall) out_d = {out_q[2*NCH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      csn_s  <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      in_q   <= '0;
      out_q  <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_s <= {sclk_s[0], sclk_i};
      csn_s  <= {csn_s[0], csn_i};
      mosi_s <= {mosi_s[0], mosi_i};
      sclk_d <= sclk_s[1];
      csn_d  <= csn_s[1];
      in_q   <= in_d;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign miso_o   = cs_act & out_q[2*NCH-1];
  assign commit_o = cs_rise & (cnt_q == CNT_OK);
  assign cmd_o    = in_q;
endmodule

// File: rtl/lsd_cfg_regs.sv
module lsd_cfg_regs
  import lsd_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic                   commit_i,
  input  logic [ADDR_W+NCH-1:0]  cmd_i,
  output logic [NCH-1:0]         gate_o,
  output logic [NCH-1:0]         mode_o,
  output logic [RCFG_W-1:0]      rcfg_o,
  output logic [NCH-1:0]         mask_o,
  output logic [NCH-1:0]         mask_eff_o
);
  localparam int CMD_W = ADDR_W + NCH;

  logic [ADDR_W-1:0] addr;
  logic [NCH-1:0]    data;
  logic              wr;
  logic [NCH-1:0]    gate_q, gate_d, mode_q, mode_d, mask_q, mask_d;
  logic [RCFG_W-1:0] rcfg_q, rcfg_d;

  always_comb begin
    addr   = cmd_i[CMD_W-1 -: ADDR_W];
    data   = cmd_i[NCH-1:0];
    wr     = commit_i & ~addr[ADDR_W-1];
    mode_d = (wr && addr == ADR_MODE) ? data : mode_q;
    rcfg_d = (wr && addr == ADR_RCFG) ? RCFG_W'(data) : rcfg_q;
    mask_d = (wr && addr == ADR_MASK) ? data : mask_q;
    if (!en_i)                        gate_d = '0;
    else if (wr && addr == ADR_GATE)  gate_d = data;
    else                              gate_d = gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      mode_q <= '0;
      rcfg_q <= '0;
      mask_q <= '0;
    end else begin
      gate_q <= gate_d;
      mode_q <= mode_d;
      rcfg_q <= rcfg_d;
      mask_q <= mask_d;
    end
  end

  assign gate_o     = gate_q;
  assign mode_o     = mode_q;
  assign rcfg_o     = rcfg_q;
  assign mask_o     = mask_q;
  // old & new: unmasking waits one more frame, masking takes effect at once
  assign mask_eff_o = mask_q & mask_d;
endmodule

// File: rtl/lsd_fault_flags.sv
module lsd_fault_flags #(
  parameter int NCH = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               commit_i,
  input  logic [NCH-1:0]     rpt_vld_i,
  input  logic [2*NCH-1:0]   rpt_code_i,
  input  logic [NCH-1:0]     stat_i,
  input  logic [NCH-1:0]     mask_i,
  input  logic [NCH-1:0]     mask_eff_i,
  output logic [2*NCH-1:0]   snap_o,
  output logic               fault_flag_n_o,
  output logic               stat_flag_n_o
);
  logic [2*NCH-1:0] lat_q, lat_d;
  logic [NCH-1:0]   hit;
  logic             ff_q, ff_d, sf_q, sf_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic take;
    always_comb begin
      take = en_i & rpt_vld_i[c] & (|rpt_code_i[2*c +: 2]);
      if (!en_i)      lat_d[2*c +: 2] = 2'b00;
      else if (take)  lat_d[2*c +: 2] = rpt_code_i[2*c +: 2];
      else if (commit_i) lat_d[2*c +: 2] = 2'b00;
      else            lat_d[2*c +: 2] = lat_q[2*c +: 2];
      hit[c] = |lat_q[2*c +: 2];
    end
  end

  always_comb begin
    if (!en_i)          ff_d = 1'b1;
    else if (commit_i)  ff_d = ~|(hit & mask_eff_i);
    else                ff_d = ff_q;
    sf_d = ~(en_i & (|(stat_i & mask_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      ff_q  <= 1'b1;
      sf_q  <= 1'b1;
    end else begin
      lat_q <= lat_d;
      ff_q  <= ff_d;
      sf_q  <= sf_d;
    end
  end

  assign snap_o         = lat_q;
  assign fault_flag_n_o = ff_q;
  assign stat_flag_n_o  = sf_q;
endmodule

// File: rtl/lsd_serial_regs.sv
module lsd_serial_regs
  import lsd_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               csn_i,
  input  logic               mosi_i,
  output logic               miso_o,
  input  logic               en_i,
  input  logic [NCH-1:0]     rpt_vld_i,
  input  logic [2*NCH-1:0]   rpt_code_i,
  input  logic [NCH-1:0]     stat_i,
  output logic [NCH-1:0]     gate_sel_o,
  output logic [NCH-1:0]     latch_off_o,
  output logic [1:0]         thr_lo_o,
  output logic               rfr_lo_o,
  output logic [1:0]         thr_hi_o,
  output logic               rfr_hi_o,
  output logic               fault_flag_n_o,
  output logic               stat_flag_n_o
);
  localparam int CMD_W = ADDR_W + NCH;

  logic [1:0]        rst_sync;
  logic              rst_ns;
  logic              commit;
  logic [CMD_W-1:0]  cmd;
  logic [2*NCH-1:0]  snap;
  logic [RCFG_W-1:0] rcfg;
  logic [NCH-1:0]    mask_q, mask_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  lsd_spi_front #(.NCH(NCH)) u_front (
    .clk(clk), .rst_n(rst_ns), .sclk_i(sclk_i), .csn_i(csn_i), .mosi_i(mosi_i),
    .snap_i(snap), .miso_o(miso_o), .commit_o(commit), .cmd_o(cmd)
  );

  lsd_cfg_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_ns), .en_i(en_i), .commit_i(commit), .cmd_i(cmd),
    .gate_o(gate_sel_o), .mode_o(latch_off_o), .rcfg_o(rcfg),
    .mask_o(mask_q), .mask_eff_o(mask_eff)
  );

  lsd_fault_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_ns), .en_i(en_i), .commit_i(commit),
    .rpt_vld_i(rpt_vld_i), .rpt_code_i(rpt_code_i), .stat_i(stat_i),
    .mask_i(mask_q), .mask_eff_i(mask_eff), .snap_o(snap),
    .fault_flag_n_o(fault_flag_n_o), .stat_flag_n_o(stat_flag_n_o)
  );

  assign thr_lo_o = rcfg[1:0];
  assign rfr_lo_o = rcfg[2];
  assign thr_hi_o = rcfg[4:3];
  assign rfr_hi_o = rcfg[5];
endmodule

// File: rtl/lsd_serial_regs_chk.sv
module lsd_serial_regs_chk #(
  parameter int NCH = 6,
  parameter int CMD_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             commit,
  input logic [CMD_W-1:0] cmd,
  input logic [NCH-1:0]   mask_q,
  input logic [NCH-1:0]   gate_sel_o,
  input logic [NCH-1:0]   latch_off_o,
  input logic [5:0]       rcfg,
  input logic             fault_flag_n_o,
  input logic             stat_flag_n_o
);
  assert_softreset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (gate_sel_o == '0 && fault_flag_n_o && stat_flag_n_o));

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(latch_off_o) && $stable(rcfg)));

  assert_null_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd[CMD_W-1] && en_i) |=> ($stable(gate_sel_o) && $stable(latch_off_o) && $stable(rcfg)));

  assert_fault_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && en_i) |=> $stable(fault_flag_n_o));

  assert_stat_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> stat_flag_n_o);
endmodule

bind lsd_serial_regs lsd_serial_regs_chk #(.NCH(NCH), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .en_i(en_i), .commit(commit), .cmd(cmd),
  .mask_q(mask_q), .gate_sel_o(gate_sel_o), .latch_off_o(latch_off_o),
  .rcfg(rcfg), .fault_flag_n_o(fault_flag_n_o), .stat_flag_n_o(stat_flag_n_o)
);

// File: tb/lsd_serial_regs_tb.sv
`timescale 1ns/100ps
module lsd_serial_regs_tb;
  localparam int NCH = 6;
  localparam int HP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, en = 1'b1;
  logic [NCH-1:0]   rpt_vld = '0;
  logic [2*NCH-1:0] rpt_code = '0;
  logic [NCH-1:0]   stat = '0;
  logic miso, ffn, sfn, rfr_lo, rfr_hi;
  logic [NCH-1:0] gate, loff;
  logic [1:0] thr_lo, thr_hi;
  logic [11:0] rd;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lsd_serial_regs #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi), .miso_o(miso),
    .en_i(en), .rpt_vld_i(rpt_vld), .rpt_code_i(rpt_code), .stat_i(stat),
    .gate_sel_o(gate), .latch_off_o(loff), .thr_lo_o(thr_lo), .rfr_lo_o(rfr_lo),
    .thr_hi_o(thr_hi), .rfr_hi_o(rfr_hi), .fault_flag_n_o(ffn), .stat_flag_n_o(sfn)
  );

  // {addr, data, expected gate, expected mode, expected config}
  localparam logic [26:0] VEC [8] = '{
    {3'b000, 6'b101010, 6'b000000, 6'b101010, 6'b000000},
    {3'b001, 6'b110011, 6'b110011, 6'b101010, 6'b000000},
    {3'b010, 6'b100110, 6'b110011, 6'b101010, 6'b100110},
    {3'b100, 6'b111111, 6'b110011, 6'b101010, 6'b100110},
    {3'b111, 6'b000000, 6'b110011, 6'b101010, 6'b100110},
    {3'b011, 6'b000000, 6'b110011, 6'b101010, 6'b100110},
    {3'b001, 6'b000001, 6'b000001, 6'b101010, 6'b100110},
    {3'b000, 6'b000000, 6'b000001, 6'b000000, 6'b100110}
  };

  function automatic logic [5:0] cfg_now();
    return {rfr_hi, thr_hi, rfr_lo, thr_lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic frame(input logic [8:0] cmd, input int nclk);
    logic [11:0] bits;
    bits = {3'b000, cmd};
    rd = '0;
    @(negedge clk) csn = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      mosi = bits[11 - (i % 12)];
      repeat (HP) @(negedge clk);
      rd = {rd[10:0], miso};
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    csn = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic report(input int ch, input logic [1:0] code);
    @(negedge clk);
    rpt_vld[ch] = 1'b1;
    rpt_code[2*ch +: 2] = code;
    @(negedge clk);
    rpt_vld = '0;
    rpt_code = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 gate", gate, 0);
    chk("R1 mode", loff, 0);
    chk("R1 cfg", cfg_now(), 0);
    chk("R1 flags", {ffn, sfn}, 2'b11);
    chk("R1 miso", miso, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 vector walk
    for (int v = 0; v < 8; v++) begin
      frame(VEC[v][26:18], 12);
      chk("R2 gate", gate, VEC[v][17:12]);
      chk("R2 mode", loff, VEC[v][11:6]);
      chk("R3 cfg", cfg_now(), VEC[v][5:0]);
    end

    // R5 wrong-length frames
    report(0, 2'b11);
    frame({3'b001, 6'b111000}, 8);
    chk("R5 short", gate, 6'b000001);
    frame({3'b010, 6'b011001}, 13);
    chk("R5 long", cfg_now(), 6'b100110);
    frame({3'b100, 6'b0}, 12);
    chk("R5 latch kept", rd, 12'b00_00_00_00_00_11);

    // R6 readback and clear
    report(0, 2'b11);
    report(5, 2'b01);
    report(3, 2'b00);
    frame({3'b100, 6'b0}, 12);
    chk("R6 readback", rd, 12'b01_00_00_00_00_11);
    chk("R7 all masked", ffn, 1'b1);
    frame({3'b100, 6'b0}, 12);
    chk("R6 cleared", rd, 12'h000);

    // R6 report across frame end
    @(negedge clk);
    rpt_vld[4] = 1'b1; rpt_code[9:8] = 2'b10;
    frame({3'b100, 6'b0}, 12);
    @(negedge clk);
    rpt_vld = '0; rpt_code = '0;
    chk("R6 collide rd", rd, 12'b00_10_00_00_00_00);
    frame({3'b100, 6'b0}, 12);
    chk("R6 collide kept", rd, 12'b00_10_00_00_00_00);

    // R8 R7 unmask: status after one frame, fault after two
    stat[2] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 stat masked", sfn, 1'b1);
    report(2, 2'b10);
    frame({3'b011, 6'b000100}, 12);
    chk("R8 stat unmasked", sfn, 1'b0);
    chk("R8 fault one frame", ffn, 1'b1);
    report(2, 2'b10);
    frame({3'b100, 6'b0}, 12);
    chk("R7 fault two frames", ffn, 1'b0);
    frame({3'b100, 6'b0}, 12);
    chk("R7 fault gone", ffn, 1'b1);
    // R8 mask again: both follow in one frame
    report(2, 2'b10);
    frame({3'b011, 6'b000000}, 12);
    chk("R8 remask fault", ffn, 1'b1);
    chk("R8 remask stat", sfn, 1'b1);
    stat = '0;

    // R9 soft reset
    frame({3'b001, 6'b111111}, 12);
    frame({3'b011, 6'b000001}, 12);
    stat[0] = 1'b1;
    report(0, 2'b11);
    frame({3'b100, 6'b0}, 12);
    chk("R9 pre fault", ffn, 1'b0);
    chk("R9 pre stat", sfn, 1'b0);
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 gate cleared", gate, 0);
    chk("R9 flags reset", {ffn, sfn}, 2'b11);
    frame({3'b001, 6'b010101}, 12);
    chk("R9 gate ignored", gate, 0);
    frame({3'b010, 6'b011011}, 12);
    chk("R9 cfg writable", cfg_now(), 6'b011011);
    report(1, 2'b01);
    @(negedge clk) en = 1'b1;
    stat = '0;
    frame({3'b100, 6'b0}, 12);
    chk("R9 latch empty", rd, 12'h000);
    chk("R9 gate stays", gate, 0);
    frame({3'b001, 6'b000111}, 12);
    chk("R9 gate after", gate, 6'b000111);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule